// File: doc/BRIEF.md
# Synchronous Burst Static RAM

This block is a small on-chip static RAM with a 32-bit word split into four byte lanes. Every address, data and control input is sampled on the rising clock edge. An access begins when one of two load strobes is low while the chip is selected. That edge latches a burst base address. Each later cycle may step an internal 2-bit counter to reach the other three words of the aligned four-word group, either in linear order or in interleaved order. The address can also be reloaded on every cycle, so the burst logic need not be used.

Read latency is set by a mode input. In flow-through mode the word appears in the cycle after its address edge. In pipelined mode an extra output register adds one cycle. Writes can cover all four bytes at once or only the lanes picked by per-byte selects. An output-enable input and a doze input gate the read port without waiting for a clock edge. While doze is high the memory keeps its contents and performs no accesses.

Top module: `sbsram_core`

## Requirements
- R1: During and right after synchronous reset, `rvalid` is 0.
- R2: With `pipe_mode`=0, a selected load at edge T reads `mem[addr]`. The word is on `rdata` with `rvalid`=1 after edge T.
- R3: With `pipe_mode`=1, the read word appears only after edge T+1. After edge T `rvalid` still reflects the earlier, idle cycle.
- R4: With `lin_order`=1, each cycle with `step_n` low and no load adds one to the burst count. The low two address bits are the base low bits plus the count, modulo 4. The upper bits are unchanged, so a burst of five wraps back to the base.
- R5: With `lin_order`=0, the low two address bits are the base low bits XOR the count, giving the order s, s^1, s^2, s^3.
- R6: A cycle with no load and `step_n` high repeats the current burst address.
- R7: With `wr_byte_n`=0 and `wr_all_n`=1, byte lane i (bits 8i+7:8i) is written only where `byte_sel_n[i]`=0. The other lanes keep their old value.
- R8: `wr_all_n`=0 writes all four lanes regardless of `byte_sel_n`. It takes priority over the byte-write controls.
- R9: A load through `load_rd_n` is always a read: the write controls are ignored in that cycle. `load_rd_n` takes priority over `load_n`.
- R10: The chip is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0 at a load edge. A load while not selected ends the burst. `rvalid` is 0 from the next cycle, and later step cycles perform no read or write.
- R11: A new address may be loaded on every cycle. Back-to-back loads give one access per cycle with no idle cycles between them.
- R12: `out_en_n`=1 forces `rvalid`=0 and `rdata`=0 at once, without a clock edge.
- R13: While `doze`=1, no read or write takes place and the burst state is frozen. `rvalid` and `rdata` are 0, and the memory contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address, latched at a load |
| wdata | input | DATA_W | Write data |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| load_rd_n | input | 1 | Read-only load strobe, active low, priority |
| load_n | input | 1 | General load strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| lin_order | input | 1 | 1 = linear, 0 = interleaved burst order |
| pipe_mode | input | 1 | 1 = pipelined, 0 = flow-through read |
| wr_all_n | input | 1 | Write all bytes, active low |
| wr_byte_n | input | 1 | Byte write enable, active low |
| byte_sel_n | input | DATA_W/8 | Per-lane byte select, active low |
| out_en_n | input | 1 | Output enable, active low, asynchronous |
| doze | input | 1 | Sleep, active high, asynchronous gating |
| rdata | output | DATA_W | Read data, 0 when not valid |
| rvalid | output | 1 | Read data valid |

## Verification
The bench builds the block with its defaults: ADDR_W=6 (a 64-word array) and DATA_W=32 (four byte lanes). This lets a full reference copy of memory be kept and every read compared against it. The six-bit address covers several four-word groups. Bursts are started at bases with different low bits, so the linear wrap and the interleaved XOR order are each exercised from a non-zero start. Four lanes are enough to mix selected and unselected bytes in one write.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    localparam int BURST_W = 2;

    typedef logic [BURST_W-1:0] boff_t;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Offset within the four-word group for a given start and count.
    function automatic boff_t burst_offset(input boff_t start, input boff_t cnt, input logic lin);
        boff_t r;
        if (lin) r = start + cnt;
        else     r = start ^ cnt;
        return r;
    endfunction

    function automatic logic chip_selected(input logic a_n, input logic b, input logic c_n);
        return !a_n && b && !c_n;
    endfunction

endpackage

// File: rtl/sbsram_seq.sv
module sbsram_seq
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              load_rd_n,
    input  logic              load_n,
    input  logic              step_n,
    input  logic              lin_order,
    input  logic              wr_all_n,
    input  logic              wr_byte_n,
    input  logic [NBYTES-1:0] byte_sel_n,
    input  logic              doze,
    output op_e               acc_op,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [NBYTES-1:0] acc_be
);

    logic [ADDR_W-1:0] base_q, base_d;
    boff_t             cnt_q, cnt_d;
    logic              active_q, active_d;
    logic              sel, strobe, wr_any;
    logic [NBYTES-1:0] be_req;

    // Global write overrides the per-lane selects.
    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign be_req[g] = !wr_all_n || (!wr_byte_n && !byte_sel_n[g]);
    end

    assign sel    = chip_selected(sel_a_n, sel_b, sel_c_n);
    assign strobe = !load_rd_n || !load_n;
    assign wr_any = |be_req;

    always_comb begin
        base_d   = base_q;
        cnt_d    = cnt_q;
        active_d = active_q;
        acc_op   = OP_NONE;
        acc_addr = base_q;
        if (!doze) begin
            if (strobe) begin
                if (sel) begin
                    base_d   = addr;
                    cnt_d    = '0;
                    active_d = 1'b1;
                    acc_addr = addr;
                    acc_op   = (!load_rd_n || !wr_any) ? OP_READ : OP_WRITE;
                end else begin
                    active_d = 1'b0;
                end
            end else if (active_q) begin
                if (!step_n) cnt_d = cnt_q + 2'd1;
                acc_addr = {base_q[ADDR_W-1:BURST_W],
                            burst_offset(base_q[BURST_W-1:0], cnt_d, lin_order)};
                acc_op   = wr_any ? OP_WRITE : OP_READ;
            end
        end
    end

    assign acc_be = (acc_op == OP_WRITE) ? be_req : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q   <= '0;
            cnt_q    <= '0;
            active_q <= 1'b0;
        end else begin
            base_q   <= base_d;
            cnt_q    <= cnt_d;
            active_q <= active_d;
        end
    end

    // R6: hold cycles keep the burst position
    a_r6_hold_position: assert property (@(posedge clk) disable iff (rst)
        (!doze && !strobe && active_q && step_n) |=> (cnt_q == $past(cnt_q) && base_q == $past(base_q)));

    // R4: a step cycle moves the count by exactly one, wrapping
    a_r4_count_step: assert property (@(posedge clk) disable iff (rst)
        (!doze && !strobe && active_q && !step_n) |=> (cnt_q == boff_t'($past(cnt_q) + 2'd1)));

    // R10: a load while not selected ends the burst
    a_r10_deselect: assert property (@(posedge clk) disable iff (rst)
        (!doze && strobe && !sel) |=> !active_q);

    // R13: doze freezes the burst state
    a_r13_doze_freeze: assert property (@(posedge clk) disable iff (rst)
        doze |=> (active_q == $past(active_q) && cnt_q == $past(cnt_q) && base_q == $past(base_q)));

    // R9: the read-only strobe never issues a write
    a_r9_load_rd_reads: assert property (@(posedge clk) disable iff (rst)
        (!doze && !load_rd_n) |-> (acc_op != OP_WRITE));

endmodule

// File: rtl/sbsram_store.sv
module sbsram_store
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  op_e               op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W/8-1:0] be,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q,
    output logic              qv
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int NBYTES = DATA_W / 8;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (op == OP_WRITE) begin
            for (int i = 0; i < NBYTES; i++) begin
                if (be[i]) mem[addr][8*i +: 8] <= wdata[8*i +: 8];
            end
        end
        if (op == OP_READ) q <= mem[addr];
    end

    always_ff @(posedge clk) begin
        if (rst) qv <= 1'b0;
        else     qv <= (op == OP_READ);
    end

    // R8: a full-lane write lands the whole word
    a_r8_full_write: assert property (@(posedge clk) disable iff (rst)
        (op == OP_WRITE && &be) |=> (mem[$past(addr)] == $past(wdata)));

    // R2: the captured word matches the array at the read address
    a_r2_read_word: assert property (@(posedge clk) disable iff (rst)
        (op == OP_READ) |=> (q == mem[$past(addr)]));

endmodule

// File: rtl/sbsram_outq.sv
module sbsram_outq #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] q1,
    input  logic              v1,
    input  logic              pipe_mode,
    input  logic              out_en_n,
    input  logic              doze,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    logic [DATA_W-1:0] q2;
    logic              v2;

    always_ff @(posedge clk) begin
        if (rst) begin
            q2 <= '0;
            v2 <= 1'b0;
        end else begin
            q2 <= q1;
            v2 <= v1;
        end
    end

    assign rvalid = (pipe_mode ? v2 : v1) && !out_en_n && !doze;
    assign rdata  = rvalid ? (pipe_mode ? q2 : q1) : '0;

    // R12: gated output never shows data
    a_r12_gated_zero: assert property (@(posedge clk) disable iff (rst)
        (out_en_n || doze) |-> (rdata == '0));

endmodule

// File: rtl/sbsram_core.sv
module sbsram_core
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                sel_a_n,
    input  logic                sel_b,
    input  logic                sel_c_n,
    input  logic                load_rd_n,
    input  logic                load_n,
    input  logic                step_n,
    input  logic                lin_order,
    input  logic                pipe_mode,
    input  logic                wr_all_n,
    input  logic                wr_byte_n,
    input  logic [DATA_W/8-1:0] byte_sel_n,
    input  logic                out_en_n,
    input  logic                doze,
    output logic [DATA_W-1:0]   rdata,
    output logic                rvalid
);

    localparam int NBYTES = DATA_W / 8;

    op_e               acc_op;
    logic [ADDR_W-1:0] acc_addr;
    logic [NBYTES-1:0] acc_be;
    logic [DATA_W-1:0] q1;
    logic              v1;

    sbsram_seq #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_seq (
        .clk(clk), .rst(rst), .addr(addr),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .load_rd_n(load_rd_n), .load_n(load_n), .step_n(step_n),
        .lin_order(lin_order), .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n),
        .byte_sel_n(byte_sel_n), .doze(doze),
        .acc_op(acc_op), .acc_addr(acc_addr), .acc_be(acc_be)
    );

    sbsram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst(rst), .op(acc_op), .addr(acc_addr), .be(acc_be),
        .wdata(wdata), .q(q1), .qv(v1)
    );

    sbsram_outq #(.DATA_W(DATA_W)) u_outq (
        .clk(clk), .rst(rst), .q1(q1), .v1(v1), .pipe_mode(pipe_mode),
        .out_en_n(out_en_n), .doze(doze), .rdata(rdata), .rvalid(rvalid)
    );

    // R13: doze suppresses every array access
    a_r13_no_access: assert property (@(posedge clk) disable iff (rst)
        doze |-> (acc_op == OP_NONE));

endmodule

// File: tb/sbsram_core_test.sv
module sbsram_core_test;

    localparam int AW = 6;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic          sel_a_n, sel_b, sel_c_n;
    logic          load_rd_n, load_n, step_n;
    logic          lin_order, pipe_mode;
    logic          wr_all_n, wr_byte_n;
    logic [3:0]    byte_sel_n;
    logic          out_en_n, doze;
    logic [DW-1:0] rdata;
    logic          rvalid;

    logic [DW-1:0] ref_mem [1 << AW];
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sbsram_core #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .load_rd_n(load_rd_n), .load_n(load_n), .step_n(step_n),
        .lin_order(lin_order), .pipe_mode(pipe_mode),
        .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .byte_sel_n(byte_sel_n),
        .out_en_n(out_en_n), .doze(doze), .rdata(rdata), .rvalid(rvalid)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_word(input string req, input int a);
        chk({req, " valid"}, {31'd0, rvalid}, 32'd1);
        chk({req, " data"}, rdata, ref_mem[a]);
    endtask

    task automatic idle_in();
        load_rd_n = 1'b1; load_n = 1'b1; step_n = 1'b1;
        wr_all_n = 1'b1; wr_byte_n = 1'b1; byte_sel_n = 4'hF;
        sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic deselect();
        idle_in();
        load_n = 1'b0; sel_a_n = 1'b1;
        tick();
        idle_in();
        tick();
    endtask

    task automatic load_read(input int a);
        idle_in();
        load_n = 1'b0; addr = AW'(a);
        tick();
        idle_in();
    endtask

    function automatic logic [DW-1:0] pat(input int a);
        return 32'hA5C3_0000 ^ (32'(a) * 32'h0101_0111);
    endfunction

    task automatic t_reset();
        rst = 1'b1; idle_in();
        addr = '0; wdata = '0; lin_order = 1'b0; pipe_mode = 1'b0;
        out_en_n = 1'b0; doze = 1'b0;
        repeat (3) tick();
        chk("R1 rvalid in reset", {31'd0, rvalid}, 32'd0);
        rst = 1'b0;
        tick();
        chk("R1 rvalid after reset", {31'd0, rvalid}, 32'd0);
    endtask

    // R11: back-to-back loads, one per cycle, then R2 flow-through reads
    task automatic t_fill_and_read();
        for (int i = 0; i < 32; i++) begin
            idle_in();
            load_n = 1'b0; addr = AW'(i); wdata = pat(i); wr_all_n = 1'b0;
            ref_mem[i] = pat(i);
            tick();
        end
        for (int i = 0; i < 32; i++) begin
            idle_in();
            load_n = 1'b0; addr = AW'(i);
            tick();
            chk_word("R11 R2 back-to-back read", i);
        end
        deselect();
    endtask

    task automatic t_pipelined();
        pipe_mode = 1'b1;
        deselect();
        load_read(20);
        chk("R3 no data one cycle after load", {31'd0, rvalid}, 32'd0);
        tick();
        chk_word("R3 pipelined word", 20);
        deselect();
        pipe_mode = 1'b0;
        deselect();
    endtask

    task automatic t_linear();
        int seq [5] = '{6, 7, 4, 5, 6};
        lin_order = 1'b1;
        load_read(6);
        chk_word("R4 linear start", seq[0]);
        for (int k = 1; k < 5; k++) begin
            step_n = 1'b0;
            tick();
            chk_word("R4 linear step", seq[k]);
        end
        deselect();
    endtask

    task automatic t_interleaved();
        int seq [4] = '{9, 8, 11, 10};
        lin_order = 1'b0;
        load_read(9);
        chk_word("R5 interleaved start", seq[0]);
        for (int k = 1; k < 4; k++) begin
            step_n = 1'b0;
            tick();
            chk_word("R5 interleaved step", seq[k]);
        end
        deselect();
    endtask

    task automatic t_hold();
        lin_order = 1'b1;
        load_read(12);
        chk_word("R6 start", 12);
        tick();
        chk_word("R6 hold repeats", 12);
        step_n = 1'b0;
        tick();
        chk_word("R6 step after hold", 13);
        deselect();
    endtask

    task automatic t_byte_write();
        logic [DW-1:0] d = 32'h1122_3344;
        idle_in();
        load_n = 1'b0; addr = AW'(3); wdata = d; wr_byte_n = 1'b0; byte_sel_n = 4'b1010;
        tick();
        ref_mem[3] = (ref_mem[3] & 32'hFF00_FF00) | (d & 32'h00FF_00FF);
        deselect();
        load_read(3);
        chk_word("R7 byte lanes 0 and 2", 3);
        deselect();
    endtask

    task automatic t_global_write();
        idle_in();
        load_n = 1'b0; addr = AW'(4); wdata = 32'hCAFE_F00D;
        wr_all_n = 1'b0; wr_byte_n = 1'b0; byte_sel_n = 4'hF;
        tick();
        ref_mem[4] = 32'hCAFE_F00D;
        deselect();
        load_read(4);
        chk_word("R8 global write all lanes", 4);
        deselect();
    endtask

    task automatic t_load_rd();
        idle_in();
        load_rd_n = 1'b0; load_n = 1'b0; addr = AW'(5);
        wdata = 32'hDEAD_BEEF; wr_all_n = 1'b0;
        tick();
        chk_word("R9 read-only load returns old word", 5);
        deselect();
        load_read(5);
        chk_word("R9 write ignored", 5);
        deselect();
    endtask

    task automatic t_deselect();
        load_read(7);
        chk_word("R10 before deselect", 7);
        idle_in();
        load_n = 1'b0; sel_b = 1'b0;
        tick();
        chk("R10 deselected", {31'd0, rvalid}, 32'd0);
        idle_in();
        step_n = 1'b0; wr_all_n = 1'b0; wdata = 32'h0;
        tick();
        chk("R10 step after deselect", {31'd0, rvalid}, 32'd0);
        idle_in();
        load_read(7);
        chk_word("R10 no write while deselected", 7);
        deselect();
    endtask

    task automatic t_out_en();
        load_read(8);
        out_en_n = 1'b1;
        #1;
        chk("R12 rvalid gated", {31'd0, rvalid}, 32'd0);
        chk("R12 rdata gated", rdata, 32'd0);
        out_en_n = 1'b0;
        #1;
        chk_word("R12 re-enabled", 8);
        deselect();
    endtask

    task automatic t_doze();
        load_read(10);
        chk_word("R13 before doze", 10);
        doze = 1'b1;
        #1;
        chk("R13 outputs off", {31'd0, rvalid}, 32'd0);
        idle_in();
        load_n = 1'b0; addr = AW'(10); wdata = 32'h0; wr_all_n = 1'b0;
        tick();
        chk("R13 no read in doze", {31'd0, rvalid}, 32'd0);
        idle_in();
        doze = 1'b0;
        load_read(10);
        chk_word("R13 contents kept", 10);
        deselect();
    endtask

    initial begin
        t_reset();
        t_fill_and_read();
        t_pipelined();
        t_linear();
        t_interleaved();
        t_hold();
        t_byte_write();
        t_global_write();
        t_load_rd();
        t_deselect();
        t_out_en();
        t_doze();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule